// File: doc/BRIEF.md
# Aligned Multi-Ratio Clock Divider

This block derives two slower clocks from one input clock. The first output runs at half the input rate. The second runs at a quarter or a sixth of the input rate, and a select input chooses between the two. Both dividers are registers on the rising edge of the same input clock. Wherever the two outputs rise on the same cycle, they therefore rise on the same input edge.

A clock-enable path starts and stops both dividers together. The enable input is captured on the falling input edge. The internal enable can therefore only change while the input clock is low, and each rising edge sees a settled value. A marker output is high for one enabled cycle each time both divided outputs rise together. Downstream logic uses it to find the common phase.

An active-low asynchronous reset puts every divider register into a fixed starting state. Several copies of the block can be aligned this way by resetting them together.

Top module: `aligned_clk_div`

## Requirements
- R1: While enabled, `div2_o` inverts on every rising edge of `clk_i`. Its period is therefore two input cycles.
- R2: While enabled, `div46_o` has a period of 4 input cycles when the active ratio is 0 and 6 input cycles when it is 1. `sel_i` = 0 selects divide-by-4 and `sel_i` = 1 selects divide-by-6. Each period begins with the high half: 2 high then 2 low, or 3 high then 3 low.
- R3: After reset all outputs are low. On the first enabled rising edge, `div2_o` and `div46_o` both go high. Every rise of `div46_o` happens on an edge where `div2_o` also rises.
- R4: `en_i` is sampled only on the falling edge of `clk_i`. A pulse on `en_i` that does not span a falling edge has no effect. A pulse that spans exactly one falling edge allows exactly one rising edge to advance the dividers.
- R5: `phase_o` is high after exactly those enabled edges on which `div2_o` and `div46_o` both rose. It drops on the next enabled edge.
- R6: While the captured enable is low, all three outputs and the divider counts hold. When the enable returns, the output sequence continues from where it stopped.
- R7: `sel_i` is sampled only on the rising edge that starts a new `div46_o` period, including the first one after reset. A change in the middle of a period never shortens or stretches that period.
- R8: Asserting `rst_ni` low forces all outputs low at once, without waiting for a clock edge. After release, the sequence restarts exactly as after the first reset.
- R9: With `en_i` and `sel_i` held low and the clock running, all outputs stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock; dividers use its rising edge, enable capture uses its falling edge |
| rst_ni | input | 1 | Active-low asynchronous reset of all divider state |
| en_i | input | 1 | Divider enable, captured on the falling edge of `clk_i` |
| sel_i | input | 1 | Ratio select for `div46_o`: 0 = divide by 4, 1 = divide by 6 |
| div2_o | output | 1 | Input clock divided by 2 |
| div46_o | output | 1 | Input clock divided by 4 or 6 |
| phase_o | output | 1 | High for one enabled cycle when both divided outputs rise together |

## Verification
Two behaviours are the hardest to reach from the ports. One is the rule that only the falling edge matters for the enable. The other is the rule that a ratio change waits for a period boundary. The stimulus places short `en_i` pulses at sub-cycle offsets: one entirely inside the high phase, one entirely inside the low phase, and one that straddles a single falling edge. It then checks that the outputs advance by zero, zero and exactly one edge. For the ratio, `sel_i` is flipped two edges into a divide-by-4 period, and the bench confirms that the old period completes unchanged before the six-cycle pattern begins.

// File: rtl/acd_pkg.sv
`timescale 1ns/1ps
package acd_pkg;
  typedef enum logic {
    RATIO_LO = 1'b0,
    RATIO_HI = 1'b1
  } ratio_e;
endpackage

// File: rtl/acd_en_capture.sv
`timescale 1ns/1ps
module acd_en_capture (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic en_o
);
  logic en_q;

  // falling-edge capture: internal enable only moves while clk_i is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_i;
  end

  assign en_o = en_q;

  always @(en_q) begin
    if (rst_ni) begin
      AST_EN_CLK_LOW: assert (clk_i == 1'b0) else $error("enable moved while clk high"); // R4
    end
  end
endmodule

// File: rtl/acd_toggle_div.sv
`timescale 1ns/1ps
module acd_toggle_div (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_i,
  output logic q_o,
  output logic rise_o
);
  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= 1'b0;
    else if (ce_i) q_q <= ~q_q;
  end

  assign q_o    = q_q;
  assign rise_o = ~q_q;

  AST_DIV2_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i |=> (q_o != $past(q_o))) else $error("div2 missed toggle"); // R1
  AST_DIV2_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> $stable(q_o)) else $error("div2 moved while disabled"); // R6
endmodule

// File: rtl/acd_sel_div.sv
`timescale 1ns/1ps
module acd_sel_div
  import acd_pkg::*;
#(
  parameter int unsigned LO_RATIO = 4,
  parameter int unsigned HI_RATIO = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_i,
  input  logic sel_i,
  output logic q_o,
  output logic rise_o
);
  localparam int unsigned CNT_W = $clog2(HI_RATIO);
  localparam logic [CNT_W-1:0] LO_LAST = CNT_W'(LO_RATIO - 1);
  localparam logic [CNT_W-1:0] HI_LAST = CNT_W'(HI_RATIO - 1);
  localparam logic [CNT_W-1:0] LO_HALF = CNT_W'(LO_RATIO / 2);
  localparam logic [CNT_W-1:0] HI_HALF = CNT_W'(HI_RATIO / 2);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  ratio_e           ratio_q, ratio_d;
  logic             q_q, q_d;
  logic             wrap;

  assign wrap = (cnt_q == '0);

  // down-counter; ratio latched only at period start
  always_comb begin
    ratio_d = ratio_q;
    cnt_d   = cnt_q - ONE;
    if (wrap) begin
      ratio_d = ratio_e'(sel_i);
      cnt_d   = sel_i ? HI_LAST : LO_LAST;
    end
    q_d = (cnt_d >= ((ratio_d == RATIO_HI) ? HI_HALF : LO_HALF));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ratio_q <= RATIO_LO;
      q_q     <= 1'b0;
    end else if (ce_i) begin
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
      q_q     <= q_d;
    end
  end

  assign q_o    = q_q;
  assign rise_o = wrap;

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(HI_RATIO)) else $error("count out of range"); // R2
  AST_RATIO_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ratio_q) |-> ($past(cnt_q) == '0)) else $error("ratio changed mid-period"); // R7
  AST_DIVB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> ($stable(cnt_q) && $stable(q_o))) else $error("divb moved while disabled"); // R6
endmodule

// File: rtl/acd_phase_mark.sv
`timescale 1ns/1ps
module acd_phase_mark (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_i,
  input  logic a_rise_i,
  input  logic b_rise_i,
  output logic phase_o
);
  logic phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   phase_q <= 1'b0;
    else if (ce_i) phase_q <= a_rise_i & b_rise_i;
  end

  assign phase_o = phase_q;

  AST_PHASE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o && ce_i) |=> !phase_o) else $error("phase wider than one cycle"); // R5
endmodule

// File: rtl/aligned_clk_div.sv
`timescale 1ns/1ps
module aligned_clk_div #(
  parameter int unsigned LO_RATIO = 4,
  parameter int unsigned HI_RATIO = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic sel_i,
  output logic div2_o,
  output logic div46_o,
  output logic phase_o
);
  logic ce;
  logic a_rise, b_rise;

  acd_en_capture u_en (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .en_o  (ce)
  );

  acd_toggle_div u_div2 (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ce_i  (ce),
    .q_o   (div2_o),
    .rise_o(a_rise)
  );

  acd_sel_div #(
    .LO_RATIO(LO_RATIO),
    .HI_RATIO(HI_RATIO)
  ) u_div46 (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ce_i  (ce),
    .sel_i (sel_i),
    .q_o   (div46_o),
    .rise_o(b_rise)
  );

  acd_phase_mark u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ce_i    (ce),
    .a_rise_i(a_rise),
    .b_rise_i(b_rise),
    .phase_o (phase_o)
  );

  AST_SHARED_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div46_o) |-> $rose(div2_o)) else $error("divb rose without div2"); // R3
  AST_PHASE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o |-> (div2_o && div46_o)) else $error("phase without both high"); // R5
endmodule

// File: tb/aligned_clk_div_bench.sv
`timescale 1ns/1ps
module aligned_clk_div_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0;
  logic sel_i = 1'b0;
  logic div2_o, div46_o, phase_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  aligned_clk_div u_aligned_clk_div (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .sel_i  (sel_i),
    .div2_o (div2_o),
    .div46_o(div46_o),
    .phase_o(phase_o)
  );

  // reference model built from the requirements
  logic exp_en;
  logic m_a, m_b, m_p, m_fresh;
  int   m_pos, m_n;

  always @(negedge clk or negedge rst_ni) begin
    if (!rst_ni) exp_en = 1'b0;
    else         exp_en = en_i;
  end

  always @(posedge clk or negedge rst_ni) begin
    logic old_a, old_b;
    if (!rst_ni) begin
      m_a = 0; m_b = 0; m_p = 0; m_fresh = 1; m_pos = 0; m_n = 4;
    end else if (exp_en) begin
      old_a = m_a; old_b = m_b;
      if (m_fresh || m_pos == m_n - 1) begin
        m_n = sel_i ? 6 : 4; m_pos = 0; m_fresh = 0;
      end else begin
        m_pos = m_pos + 1;
      end
      m_a = ~m_a;
      m_b = (m_pos < m_n / 2);
      m_p = m_a & ~old_a & m_b & ~old_b;
    end
  end

  task automatic chk(string tag, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: {div2,div46,phase} actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic edge_check(string tag);
    @(posedge clk); #1;
    chk(tag, {div2_o, div46_o, phase_o}, {m_a, m_b, m_p});
  endtask

  task automatic do_reset();
    en_i = 0;
    rst_ni = 0;
    #7;
    @(posedge clk); #1;
    rst_ni = 1;
  endtask

  task automatic t_reset_state();
    sel_i = 0; en_i = 0; rst_ni = 0;
    repeat (3) @(posedge clk);
    #1 chk("R3 reset low", {div2_o, div46_o, phase_o}, 3'b000);
    rst_ni = 1;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1;
      chk("R9 idle low", {div2_o, div46_o, phase_o}, 3'b000);
    end
  endtask

  task automatic t_run(logic sel, int n, string tag);
    do_reset();
    sel_i = sel;
    en_i = 1;
    for (int i = 0; i < n; i++) edge_check(tag);
  endtask

  task automatic t_hold();
    logic [2:0] saved;
    do_reset();
    sel_i = 0; en_i = 1;
    repeat (3) edge_check("R6 pre-hold");
    en_i = 0;
    edge_check("R6 last enabled");
    saved = {div2_o, div46_o, phase_o};
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #1;
      chk("R6 hold", {div2_o, div46_o, phase_o}, saved);
    end
    en_i = 1;
    for (int i = 0; i < 8; i++) edge_check("R6 resume");
  endtask

  task automatic t_en_window();
    logic [2:0] saved;
    do_reset();
    sel_i = 0; en_i = 1;
    repeat (2) edge_check("R4 setup");
    en_i = 0;
    edge_check("R4 setup");
    @(posedge clk); #1;
    saved = {div2_o, div46_o, phase_o};
    // pulse wholly inside high phase
    @(posedge clk); #0.5 en_i = 1; #1 en_i = 0;
    repeat (2) @(posedge clk);
    #1 chk("R4 high-phase pulse ignored", {div2_o, div46_o, phase_o}, saved);
    // pulse wholly inside low phase
    @(negedge clk); #0.5 en_i = 1; #1 en_i = 0;
    repeat (2) @(posedge clk);
    #1 chk("R4 low-phase pulse ignored", {div2_o, div46_o, phase_o}, saved);
    // pulse spanning one falling edge: exactly one advance
    @(posedge clk); #1 en_i = 1;
    @(negedge clk); #1 en_i = 0;
    repeat (3) @(posedge clk);
    #1 chk("R4 single advance div2", {2'b00, div2_o}, {2'b00, ~saved[2]});
    chk("R4 single advance model", {div2_o, div46_o, phase_o}, {m_a, m_b, m_p});
  endtask

  task automatic t_sel_switch();
    do_reset();
    sel_i = 0; en_i = 1;
    repeat (2) edge_check("R7 before switch");
    sel_i = 1;
    for (int i = 0; i < 14; i++) edge_check("R7 after switch");
    // explicit: 4-cycle period completed, then 3 high
    sel_i = 0;
    for (int i = 0; i < 8; i++) edge_check("R7 back to 4");
  endtask

  task automatic t_mid_reset();
    do_reset();
    sel_i = 1; en_i = 1;
    repeat (4) edge_check("R8 pre-reset");
    @(posedge clk); #1.5 rst_ni = 0;
    #0.5 chk("R8 async clear", {div2_o, div46_o, phase_o}, 3'b000);
    @(posedge clk); #1 rst_ni = 1;
    for (int i = 0; i < 8; i++) edge_check("R8 restart R3");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_run(1'b0, 24, "R1 R2 R3 R5 div4");
    t_run(1'b1, 24, "R1 R2 R3 R5 div6");
    t_hold();
    t_en_window();
    t_sel_switch();
    t_mid_reset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule